// File: doc/BRIEF.md
# Quadrature Phase Detector

This block measures the phase and amplitude of a sampled sine wave against a pair of reference waves, one sine and one cosine, that run at the same frequency and arrive on input ports beside the measured samples. Each valid measured sample is multiplied by both references. The two product streams are summed over a measurement window that spans a programmed whole number of reference periods. Over such a window the double-frequency part of each product sums to zero, so only a cosine term (in-phase) and a sine term (quadrature) remain.

When a window closes, both sums are captured and scaled down by a fixed arithmetic shift. An iterative vectoring CORDIC then turns them into a phase angle and a magnitude, and a single-cycle strobe marks the new result. The accumulators restart on the sample that follows the last one of a window, so consecutive windows cover the sample stream with no gaps. A synchronous clear input restarts the current window and drops every sample already in flight.

Top module: `quad_phase_det`

## Requirements
- R1: The in-phase sum is the sum of `smp*ref_sin` over the window and the quadrature sum is the sum of `smp*ref_cos`. Both are exact, computed with full-width (2*SAMP_W) products in accumulators 2*SAMP_W+PER_W+NPER_W bits wide, with no saturation.
- R2: A sample with `smp_vld` high reaches the accumulators exactly 3 cycles later. Cycles with `smp_vld` low add nothing to either sum and do not advance the window count, whatever values the data inputs carry.
- R3: A window holds exactly `per_len*num_per` valid samples and yields exactly one result. The window settings change only in cycles where `clr` is high.
- R4: Each sum is shifted right arithmetically by ACC_SHIFT and truncated to CIN_W bits. `phase` is then atan2(Q, I) of the shifted pair, a signed value in radians with 13 fraction bits (8192 = 1 rad). It covers the full range ±π by a ±π/2 pre-rotation when I is negative, and its error is at most 16 LSB.
- R5: `clr` empties the multiplier pipeline, both accumulators and the window count. Samples accepted before `clr` never contribute to a result.
- R6: `mag` equals 1.64676·sqrt(I²+Q²) of the shifted pair when GAIN_COMP is 0, and 1.0 times that value when GAIN_COMP is 1, within 0.2 % + 8 LSB.
- R7: The sample right after the last sample of a window is the first sample of the next window, with no samples lost between consecutive windows.
- R8: `done` is high for exactly one cycle per result. `phase` and `mag` hold their values until the next `done`. After reset, `done`, `phase` and `mag` are all 0.
- R9: Back-to-back windows as short as ITER+2 samples are supported. The CORDIC finishes one result before the next window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous window restart; flushes pipeline and accumulators |
| smp_vld | input | 1 | Sample valid |
| smp | input | SAMP_W | Measured sample, signed |
| ref_sin | input | SAMP_W | Sine reference sample, signed |
| ref_cos | input | SAMP_W | Cosine reference sample, signed |
| per_len | input | PER_W | Samples per reference period |
| num_per | input | NPER_W | Reference periods per window |
| done | output | 1 | One-cycle result strobe |
| phase | output | 16 | Phase, signed, radians with 13 fraction bits |
| mag | output | CIN_W+2 | Magnitude, non-negative |

## Verification
The hardest cases to reach are the window boundary under continuous input, where one window's last product and the next window's first product meet in the same accumulator update, and a clear that arrives while samples are still inside the three-stage multiplier. The stimulus covers the first case with unbroken runs of windows at several phases, including runs of the shortest legal window, where the CORDIC also has the least time to spare. For the second case it drives part of a window with a very different phase and clears on the very next cycle, then checks that only the following window yields a result. Valid-gap cycles carry junk data, so any leak of those samples into the sums would shift the measured phase.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

   localparam int ANG_W   = 16;
   localparam int MUL_LAT = 3;

   localparam logic signed [ANG_W-1:0] HALF_PI_Q = 16'sd12868;
   localparam logic signed [ANG_W-1:0] PI_Q      = 16'sd25736;

   // arctan(2^-i) in radians, 13 fraction bits
   function automatic logic signed [ANG_W-1:0] atan_step(input int i);
      case (i)
         0:       return 16'sd6434;
         1:       return 16'sd3798;
         2:       return 16'sd2007;
         3:       return 16'sd1019;
         4:       return 16'sd511;
         5:       return 16'sd256;
         6:       return 16'sd128;
         7:       return 16'sd64;
         8:       return 16'sd32;
         9:       return 16'sd16;
         10:      return 16'sd8;
         11:      return 16'sd4;
         12:      return 16'sd2;
         13:      return 16'sd1;
         default: return 16'sd0;
      endcase
   endfunction

endpackage

// File: rtl/qpd_window.sv
module qpd_window
   import qpd_pkg::*;
#(
   parameter int PER_W  = 12,
   parameter int NPER_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              in_vld,
   input  logic [PER_W-1:0]  per_len,
   input  logic [NPER_W-1:0] num_per,
   output logic              pv,
   output logic              last,
   output logic              start
);
   localparam int CNT_W = PER_W + NPER_W;

   if (MUL_LAT < 2) begin : g_bad_lat
      $error("qpd_window: multiplier latency must be at least 2");
   end

   logic [MUL_LAT-1:0] vpipe;
   logic [CNT_W-1:0]   cnt;
   logic [CNT_W-1:0]   win_len;

   assign win_len = CNT_W'(per_len) * CNT_W'(num_per);
   assign pv      = vpipe[MUL_LAT-1];
   assign last    = pv && !clr && (cnt == win_len - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (rst || clr) vpipe <= '0;
      else            vpipe <= {vpipe[MUL_LAT-2:0], in_vld};
   end

   always_ff @(posedge clk) begin
      if (rst || clr)  cnt <= '0;
      else if (pv)     cnt <= last ? '0 : cnt + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) start <= 1'b0;
      else     start <= last;
   end

   // R2: a product reaches the accumulators three cycles after its sample
   p_mult_lat_r2: assert property (@(posedge clk) disable iff (rst || clr)
      pv |-> $past(in_vld, 3));

   // R3: the count never runs past the programmed window
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
      (pv && !clr) |-> (cnt < win_len));

   // R3: a conversion starts only after a product was taken in
   p_start_src_r3: assert property (@(posedge clk) disable iff (rst)
      start |-> $past(pv));

endmodule

// File: rtl/qpd_mac.sv
module qpd_mac
   import qpd_pkg::*;
#(
   parameter int SAMP_W = 16,
   parameter int ACC_W  = 48
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     clr,
   input  logic signed [SAMP_W-1:0] a,
   input  logic signed [SAMP_W-1:0] b,
   input  logic                     pv,
   input  logic                     last,
   output logic signed [ACC_W-1:0]  sum
);
   localparam int PROD_W = 2 * SAMP_W;

   if (ACC_W < PROD_W) begin : g_bad_acc
      $error("qpd_mac: accumulator narrower than product");
   end

   logic signed [PROD_W-1:0] stg [MUL_LAT];
   logic signed [ACC_W-1:0]  acc;
   logic signed [ACC_W-1:0]  acc_nx;

   always_ff @(posedge clk) begin
      stg[0] <= PROD_W'(a) * PROD_W'(b);
      for (int k = 1; k < MUL_LAT; k++) stg[k] <= stg[k-1];
   end

   assign acc_nx = acc + ACC_W'(stg[MUL_LAT-1]);

   always_ff @(posedge clk) begin
      if (rst || clr) acc <= '0;
      else if (pv)    acc <= last ? '0 : acc_nx;
   end

   always_ff @(posedge clk) begin
      if (rst)       sum <= '0;
      else if (last) sum <= acc_nx;
   end

endmodule

// File: rtl/qpd_cordic.sv
module qpd_cordic
   import qpd_pkg::*;
#(
   parameter int IN_W      = 24,
   parameter int ITER      = 16,
   parameter bit GAIN_COMP = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    start,
   input  logic signed [IN_W-1:0]  x_in,
   input  logic signed [IN_W-1:0]  y_in,
   output logic                    done,
   output logic signed [ANG_W-1:0] phase,
   output logic [IN_W+1:0]         mag
);
   localparam int XW = IN_W + 2;
   localparam int IW = (ITER > 1) ? $clog2(ITER) : 1;

   if (ITER < 4 || ITER > 16) begin : g_bad_iter
      $error("qpd_cordic: ITER must lie in 4..16");
   end
   if (IN_W < 4) begin : g_bad_w
      $error("qpd_cordic: IN_W too small");
   end

   logic signed [XW-1:0]    xe, ye, x0, y0, xr, yr, xs, ys, xn, yn, mag_fin;
   logic signed [ANG_W-1:0] z0, zr, zn, at;
   logic [IW-1:0]           it;
   logic                    busy;
   logic signed [XW-1:0]    mag_r;

   // pre-rotation into the right half plane
   always_comb begin
      xe = XW'(x_in);
      ye = XW'(y_in);
      if (xe < 0) begin
         if (ye >= 0) begin x0 = ye;  y0 = -xe; z0 = HALF_PI_Q;  end
         else         begin x0 = -ye; y0 = xe;  z0 = -HALF_PI_Q; end
      end else begin
         x0 = xe; y0 = ye; z0 = '0;
      end
   end

   // one vectoring micro-rotation
   always_comb begin
      xs = xr >>> it;
      ys = yr >>> it;
      at = atan_step(int'(it));
      if (!yr[XW-1]) begin xn = xr + ys; yn = yr - xs; zn = zr + at; end
      else           begin xn = xr - ys; yn = yr + xs; zn = zr - at; end
   end

   if (GAIN_COMP) begin : g_comp
      localparam logic signed [XW+15:0] K_INV = (XW+16)'(19898);
      logic signed [XW+15:0] scaled;
      assign scaled  = (XW+16)'(xn) * K_INV;
      assign mag_fin = XW'(scaled >>> 15);
   end else begin : g_raw
      assign mag_fin = xn;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         xr <= '0; yr <= '0; zr <= '0; it <= '0;
         busy <= 1'b0; done <= 1'b0; phase <= '0; mag_r <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            xr <= x0; yr <= y0; zr <= z0; it <= '0; busy <= 1'b1;
         end else if (busy) begin
            xr <= xn; yr <= yn; zr <= zn; it <= it + IW'(1);
            if (it == IW'(ITER - 1)) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               phase <= zn;
               mag_r <= mag_fin;
            end
         end
      end
   end

   assign mag = mag_r;

   // R9: a window never closes while a conversion is still running
   p_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
      start |-> !busy);

   // R8: the result strobe lasts a single cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R8: a result only follows a running conversion
   p_done_src_r8: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(busy));

   // R4: phase stays within plus or minus pi
   p_phase_range_r4: assert property (@(posedge clk) disable iff (rst)
      done |-> (phase >= -PI_Q - 16'sd16 && phase <= PI_Q + 16'sd16));

   // R6: magnitude is never negative
   p_mag_pos_r6: assert property (@(posedge clk) disable iff (rst)
      done |-> !mag_r[XW-1]);

endmodule

// File: rtl/quad_phase_det.sv
module quad_phase_det
   import qpd_pkg::*;
#(
   parameter int SAMP_W    = 16,
   parameter int PER_W     = 12,
   parameter int NPER_W    = 4,
   parameter int CIN_W     = 24,
   parameter int ACC_SHIFT = 24,
   parameter int ITER      = 16,
   parameter bit GAIN_COMP = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     clr,
   input  logic                     smp_vld,
   input  logic signed [SAMP_W-1:0] smp,
   input  logic signed [SAMP_W-1:0] ref_sin,
   input  logic signed [SAMP_W-1:0] ref_cos,
   input  logic [PER_W-1:0]         per_len,
   input  logic [NPER_W-1:0]        num_per,
   output logic                     done,
   output logic signed [ANG_W-1:0]  phase,
   output logic [CIN_W+1:0]         mag
);
   localparam int WIN_W = PER_W + NPER_W;
   localparam int ACC_W = 2 * SAMP_W + WIN_W;

   if (ACC_SHIFT < 0 || ACC_W - ACC_SHIFT > CIN_W) begin : g_bad_shift
      $error("quad_phase_det: ACC_SHIFT does not fit sums into CIN_W");
   end

   logic pv, last, start;
   logic signed [SAMP_W-1:0] ref_sel [2];
   logic signed [ACC_W-1:0]  sums    [2];
   logic signed [CIN_W-1:0]  cin     [2];

   assign ref_sel[0] = ref_sin;
   assign ref_sel[1] = ref_cos;

   qpd_window #(.PER_W(PER_W), .NPER_W(NPER_W)) u_win (
      .clk(clk), .rst(rst), .clr(clr), .in_vld(smp_vld),
      .per_len(per_len), .num_per(num_per),
      .pv(pv), .last(last), .start(start));

   for (genvar p = 0; p < 2; p++) begin : g_path
      qpd_mac #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_mac (
         .clk(clk), .rst(rst), .clr(clr), .a(smp), .b(ref_sel[p]),
         .pv(pv), .last(last), .sum(sums[p]));
      assign cin[p] = CIN_W'(sums[p] >>> ACC_SHIFT);
   end

   qpd_cordic #(.IN_W(CIN_W), .ITER(ITER), .GAIN_COMP(GAIN_COMP)) u_cordic (
      .clk(clk), .rst(rst), .start(start),
      .x_in(cin[0]), .y_in(cin[1]),
      .done(done), .phase(phase), .mag(mag));

endmodule

// File: tb/sim_quad_phase_det.sv
module sim_quad_phase_det;
   localparam int  PER_W  = 8;
   localparam int  NPER_W = 3;
   localparam int  CIN_W  = 24;
   localparam int  SHIFT  = 19;
   localparam int  MAG_W  = CIN_W + 2;
   localparam real PI     = 3.14159265358979;
   localparam real KGAIN  = 1.64676;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst, clr, smp_vld;
   logic signed [15:0] smp, ref_sin, ref_cos;
   logic [PER_W-1:0]  per_len;
   logic [NPER_W-1:0] num_per;
   logic done;
   logic signed [15:0] phase;
   logic [MAG_W-1:0]  mag;

   quad_phase_det #(.SAMP_W(16), .PER_W(PER_W), .NPER_W(NPER_W), .CIN_W(CIN_W),
                    .ACC_SHIFT(SHIFT), .ITER(16), .GAIN_COMP(1'b0)) u0 (
      .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld), .smp(smp),
      .ref_sin(ref_sin), .ref_cos(ref_cos), .per_len(per_len), .num_per(num_per),
      .done(done), .phase(phase), .mag(mag));

   int checks = 0, fails = 0;
   int results = 0, expected_total = 0, hold_bad = 0;
   real   exp_ph_q[$], exp_mg_q[$];
   string tag_q[$];
   logic signed [15:0] held_ph;
   logic [MAG_W-1:0]  held_mg;
   bit    seen = 1'b0;
   real   ep, em, d;
   string tg;

   task automatic chk(input bit ok, input string req, input string what,
                      input real act, input real expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, expv);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // monitor: pops expected results as the design strobes them
   always @(negedge clk) begin
      if (!rst) begin
         if (done) begin
            results++;
            if (exp_ph_q.size() == 0) begin
               chk(1'b0, "R3", "unexpected result", real'(results), real'(expected_total));
            end else begin
               ep = exp_ph_q.pop_front();
               em = exp_mg_q.pop_front();
               tg = tag_q.pop_front();
               d  = real'(phase) - ep;
               chk(d <= 16.0 && d >= -16.0, {tg, " R4"}, "phase", real'(phase), ep);
               d  = real'(mag) - em;
               if (d < 0.0) d = -d;
               chk(d <= 0.002 * em + 8.0, {tg, " R6"}, "magnitude", real'(mag), em);
            end
            held_ph = phase;
            held_mg = mag;
            seen    = 1'b1;
         end else if (seen && (phase != held_ph || mag != held_mg)) begin
            hold_bad++;
         end
      end
   end

   // driver: one window (or its first 'cut' samples), expected pushed if keep
   task automatic drive_win(input real phi, input int amp, input int per, input int np,
                            input int gap, input int cut, input bit keep, input string tag);
      longint si = 0, sq = 0, is_, qs_;
      int n = (cut > 0) ? cut : per * np;
      for (int k = 0; k < n; k++) begin
         int  idx = k % per;
         real th  = 2.0 * PI * real'(idx) / real'(per);
         int  s   = int'(32767.0 * $sin(th));
         int  c   = int'(32767.0 * $cos(th));
         int  x   = int'(real'(amp) * $sin(th + phi));
         si += longint'(x) * longint'(s);
         sq += longint'(x) * longint'(c);
         smp_vld = 1'b1; smp = 16'(x); ref_sin = 16'(s); ref_cos = 16'(c);
         @(negedge clk);
         if (gap > 0 && (k % gap) == gap - 1) begin
            smp_vld = 1'b0; smp = 16'sd12345; ref_sin = -16'sd30000; ref_cos = 16'sd29000;
            @(negedge clk);
         end
      end
      if (keep) begin
         is_ = si >>> SHIFT;
         qs_ = sq >>> SHIFT;
         exp_ph_q.push_back($atan2(real'(qs_), real'(is_)) * 8192.0);
         exp_mg_q.push_back(KGAIN * $sqrt(real'(is_) * real'(is_) + real'(qs_) * real'(qs_)));
         tag_q.push_back(tag);
         expected_total++;
      end
   endtask

   task automatic idle(input int n);
      smp_vld = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic restart(input int per, input int np);
      smp_vld = 1'b0; clr = 1'b1; per_len = PER_W'(per); num_per = NPER_W'(np);
      @(negedge clk);
      clr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", "run did not finish", 0.0, 1.0);
      summary();
   end

   initial begin
      rst = 1'b1; clr = 1'b0; smp_vld = 1'b0; smp = '0; ref_sin = '0; ref_cos = '0;
      per_len = PER_W'(64); num_per = NPER_W'(2);
      repeat (4) @(negedge clk);
      chk(done == 1'b0 && phase == 16'sd0 && mag == '0, "R8", "reset outputs",
          real'(phase) + real'(mag) + real'(done), 0.0);
      rst = 1'b0;
      @(negedge clk);

      // R1 R7: continuous windows, positive and negative phase
      restart(64, 2);
      drive_win(0.0,  30000, 64, 2, 0, 0, 1'b1, "R1 R7");
      drive_win(0.5,  30000, 64, 2, 0, 0, 1'b1, "R1 R7");
      drive_win(1.0,  20000, 64, 2, 0, 0, 1'b1, "R1 R7");
      drive_win(-1.0, 25000, 64, 2, 0, 0, 1'b1, "R1 R7");
      idle(8);

      // R4: in-phase sum negative, pre-rotation both ways
      drive_win(2.5,  30000, 64, 2, 0, 0, 1'b1, "R4");
      drive_win(-2.5, 30000, 64, 2, 0, 0, 1'b1, "R4");
      drive_win(3.0,  30000, 64, 2, 0, 0, 1'b1, "R4");
      drive_win(-2.0, 18000, 64, 2, 0, 0, 1'b1, "R4");
      idle(8);

      // R2 R3: gaps with junk data on the inputs, different window shape
      restart(32, 4);
      drive_win(0.8,  30000, 32, 4, 5, 0, 1'b1, "R2 R3");
      drive_win(-0.3, 30000, 32, 4, 3, 0, 1'b1, "R2 R3");
      idle(8);

      // R5: partial window, clear at once, then a clean window
      restart(64, 1);
      drive_win(-2.9, 30000, 64, 1, 0, 40, 1'b0, "R5");
      restart(64, 1);
      drive_win(0.3,  30000, 64, 1, 0, 0, 1'b1, "R5");
      idle(8);

      // R9: shortest window, back to back
      restart(18, 1);
      drive_win(0.2,  30000, 18, 1, 0, 0, 1'b1, "R9 R7");
      drive_win(-0.4, 30000, 18, 1, 0, 0, 1'b1, "R9 R7");
      drive_win(1.4,  30000, 18, 1, 0, 0, 1'b1, "R9 R7");
      idle(60);

      chk(exp_ph_q.size() == 0, "R3", "results still pending", real'(exp_ph_q.size()), 0.0);
      chk(results == expected_total, "R3 R5", "result count", real'(results), real'(expected_total));
      chk(hold_bad == 0, "R8", "outputs changed between strobes", real'(hold_bad), 0.0);
      summary();
   end

endmodule